// File: doc/BRIEF.md
# Way-Configurable Write-Back Cache Tag Controller

This block holds the tag and control side of an 8-way set-associative write-back cache with sixteen one-word sets. It also keeps a behavioural data store protected by a single-error-correct, double-error-detect (SECDED) code. A request carries an address, a read/write flag, write data and the refill word that the next level would return on a read miss. The controller looks the address up, reports hit or miss and the way used, allocates on every miss, and issues a writeback pulse whenever a dirty line is evicted.

A run-time setting selects 8, 4 or 2 active ways. The lowest-numbered ways stay enabled, and a per-way power-enable output turns off the others. Before a way is gated off, the controller sweeps every set. It writes back the dirty lines of the departing ways one per cycle, lowest way first, and invalidates them. New requests are held off until the sweep ends. Growing the way count runs the same sweep, which clears the valid bits of the returning ways, so they can never produce a stale hit. For each set, the tags, valid bits, dirty bits and tree pseudo-LRU bits sit together in one array word that is read and written as a unit.

Top module: `wcache_ctrl`

## Requirements
- R1: A read that hits returns the data last written to that address, with resp_hit=1 and the way holding it.
- R2: A read miss installs req_fill as a clean line and returns it on resp_rdata. A write miss installs req_wdata as a dirty line. Both report resp_hit=0.
- R3: The victim is the lowest-numbered invalid active way. When every active way is valid, the victim comes from a 7-bit tree pseudo-LRU that is limited to the active ways, and each access points the tree away from the way it touched.
- R4: Evicting a dirty victim produces a one-cycle wb_valid pulse, together with the response, carrying the victim's address {tag, index} and its data. A clean victim produces no pulse.
- R5: cfg_ways code 0 selects 2 ways, code 1 selects 4 ways and code 2 selects 8 ways. Code 3 is ignored, and the power enables and readiness stay unchanged.
- R6: On a reduction, every valid dirty line in the departing ways is written back, lowest way first within a set, and all lines in those ways are invalidated. req_ready stays low until the sweep completes.
- R7: pwr_en bit w is 1 exactly for the active ways. During a reduction sweep the departing ways stay powered, and during a growth sweep the arriving ways are already powered.
- R8: Ways enabled by a growth start with every line invalid, so a former address misses and the lowest returning way is allocated.
- R9: A single-bit error in a stored word is corrected on a read hit, and err_count increments by one.
- R10: A double-bit error on a read hit sets resp_uncorr together with the response.
- R11: After reset all lines are invalid, 8 ways are active, pwr_en is 8'hFF, req_ready is 1 and err_count is 0.
- R12: The response for an accepted request appears exactly one clock after acceptance, and resp_way always names a powered way.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_ways | input | 2 | Requested way count: 0=2, 1=4, 2=8, 3 ignored |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 12 | Word address {tag[7:0], index[3:0]} |
| req_wdata | input | 32 | Write data |
| req_fill | input | 32 | Refill word installed on a read miss |
| req_flip | input | 39 | Error-injection mask XORed into the stored codeword |
| req_ready | output | 1 | Request accepted this cycle when high with req_valid |
| resp_valid | output | 1 | Response strobe |
| resp_hit | output | 1 | Lookup hit |
| resp_way | output | 3 | Way that hit or was allocated |
| resp_rdata | output | 32 | Read data (0 for writes) |
| resp_uncorr | output | 1 | Uncorrectable data error on this read |
| err_count | output | 16 | Saturating count of corrected errors |
| wb_valid | output | 1 | Writeback pulse |
| wb_addr | output | 12 | Writeback address |
| wb_data | output | 32 | Writeback data |
| pwr_en | output | 8 | Per-way power enable |

## Verification
The assertions assume that requests are driven only while req_ready is high and that cfg_ways holds steady while a sweep is running. They also assume req_flip sets at most two bits, so a flagged error really is a double-bit one. The stimulus waits for req_ready before every request, changes cfg_ways only between requests and keeps it fixed until readiness returns, and injects one-bit or two-bit masks only. Expected victims come from tracing the pseudo-LRU tree by hand over the access sequence.

// File: rtl/wcache_pkg.sv
package wcache_pkg;
  localparam int ADDR_W = 12;
  localparam int IDX_W  = 4;
  localparam int TAG_W  = ADDR_W - IDX_W;
  localparam int SETS   = 1 << IDX_W;
  localparam int WAYS   = 8;
  localparam int WAY_W  = $clog2(WAYS);
  localparam int DW     = 32;
  localparam int PW     = 6;
  localparam int CW     = DW + PW + 1;

  typedef enum logic {S_IDLE, S_SWEEP} ctl_state_t;

  typedef struct packed {
    logic [WAYS-1:0]             vld;
    logic [WAYS-1:0]             dty;
    logic [WAYS-2:0]             plru;
    logic [WAYS-1:0][TAG_W-1:0]  tag;
  } set_word_t;

  function automatic logic [WAYS-1:0] mask_of(logic [1:0] code);
    case (code)
      2'd0:    return 8'h03;
      2'd1:    return 8'h0F;
      default: return 8'hFF;
    endcase
  endfunction

  function automatic logic [WAY_W-1:0] lowest(logic [WAYS-1:0] v);
    logic [WAY_W-1:0] r;
    r = '0;
    for (int i = WAYS - 1; i >= 0; i--) if (v[i]) r = WAY_W'(i);
    return r;
  endfunction

  function automatic logic [WAYS-2:0] plru_touch(logic [WAYS-2:0] t, logic [WAY_W-1:0] w);
    logic [WAYS-2:0] n;
    n = t;
    n[0] = ~w[2];
    n[1 + int'(w[2])] = ~w[1];
    n[3 + int'(w[2:1])] = ~w[0];
    return n;
  endfunction

  function automatic logic [CW-1:0] secded_enc(logic [DW-1:0] d);
    logic [CW-1:0] c;
    int k;
    c = '0;
    k = 0;
    for (int p = 1; p < CW; p++)
      if ((p & (p - 1)) != 0) begin
        c[p] = d[k];
        k++;
      end
    for (int b = 0; b < PW; b++)
      for (int p = 1; p < CW; p++)
        if (((p >> b) & 1) == 1) c[1 << b] = c[1 << b] ^ c[p];
    c[0] = ^c[CW-1:1];
    return c;
  endfunction
endpackage

// File: rtl/secded_check.sv
module secded_check
  import wcache_pkg::*;
(
  input  logic [CW-1:0] cw,
  output logic [DW-1:0] data,
  output logic          single_err,
  output logic          double_err
);
  logic [PW-1:0] syn;
  logic          par;
  logic [CW-1:0] fixed;

  always_comb begin
    syn = '0;
    for (int p = 1; p < CW; p++) if (cw[p]) syn = syn ^ PW'(p);
    par = ^cw;
    fixed = cw;
    if (par && syn != '0 && int'(syn) < CW) fixed[syn] = ~cw[syn];
    data = '0;
    begin
      int k;
      k = 0;
      for (int p = 1; p < CW; p++)
        if ((p & (p - 1)) != 0) begin
          data[k] = fixed[p];
          k++;
        end
    end
  end

  assign single_err = par;
  assign double_err = !par && (syn != '0);
endmodule

// File: rtl/plru_pick.sv
module plru_pick
  import wcache_pkg::*;
(
  input  logic [WAYS-2:0]  tree,
  input  logic [WAYS-1:0]  vld,
  input  logic [WAYS-1:0]  act_mask,
  output logic [WAY_W-1:0] victim
);
  logic [WAYS-1:0] free_w;
  logic            b2, b1, b0;

  assign free_w = ~vld & act_mask;

  always_comb begin
    b2 = act_mask[4] ? tree[0] : 1'b0;
    b1 = act_mask[2] ? tree[1 + int'(b2)] : 1'b0;
    b0 = tree[3 + int'({b2, b1})];
    victim = (|free_w) ? lowest(free_w) : {b2, b1, b0};
  end
endmodule

// File: rtl/wcache_ctrl.sv
module wcache_ctrl
  import wcache_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        cfg_ways,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DW-1:0]     req_wdata,
  input  logic [DW-1:0]     req_fill,
  input  logic [CW-1:0]     req_flip,
  output logic              req_ready,
  output logic              resp_valid,
  output logic              resp_hit,
  output logic [WAY_W-1:0]  resp_way,
  output logic [DW-1:0]     resp_rdata,
  output logic              resp_uncorr,
  output logic [15:0]       err_count,
  output logic              wb_valid,
  output logic [ADDR_W-1:0] wb_addr,
  output logic [DW-1:0]     wb_data,
  output logic [WAYS-1:0]   pwr_en
);
  logic [1:0] rst_q;
  logic       rst_i_n;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) rst_q <= '0;
    else        rst_q <= {rst_q[0], 1'b1};
  assign rst_i_n = rst_q[1];

  ctl_state_t        state, state_n;
  logic [1:0]        active, active_n, target, target_n;
  logic [IDX_W-1:0]  sweep, sweep_n;
  set_word_t         tag_mem [SETS];
  logic [CW-1:0]     data_mem [SETS*WAYS];

  logic [IDX_W-1:0]  rd_idx, req_idx;
  logic [TAG_W-1:0]  req_tag;
  set_word_t         entry, entry_n;
  logic [WAYS-1:0]   act_mask, tgt_mask, range_mask, hit_vec, pend;
  logic [WAY_W-1:0]  victim, hit_way, sel_way, flush_way;
  logic              hit, accept, cfg_change;
  logic [DW-1:0]     dec_data;
  logic              dec_single, dec_double;
  logic              tag_we, data_we, wb_set, resp_hit_n, resp_unc_n, err_inc;
  logic [CW-1:0]     data_wd;
  logic [ADDR_W-1:0] wb_addr_n;
  logic [DW-1:0]     resp_rdata_n;
  logic [WAY_W-1:0]  resp_way_n;

  assign req_idx    = req_addr[IDX_W-1:0];
  assign req_tag    = req_addr[ADDR_W-1:IDX_W];
  assign rd_idx     = (state == S_SWEEP) ? sweep : req_idx;
  assign entry      = tag_mem[rd_idx];
  assign act_mask   = mask_of(active);
  assign tgt_mask   = mask_of(target);
  assign range_mask = act_mask ^ tgt_mask;
  assign pend       = entry.vld & entry.dty & range_mask;
  assign flush_way  = lowest(pend);
  assign cfg_change = (cfg_ways != 2'd3) && (cfg_ways != active);
  assign req_ready  = (state == S_IDLE) && !cfg_change;
  assign accept     = req_valid && req_ready;
  assign pwr_en     = act_mask | ((state == S_SWEEP) ? tgt_mask : '0);

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign hit_vec[w] = entry.vld[w] && act_mask[w] && (entry.tag[w] == req_tag);
  end
  assign hit     = |hit_vec;
  assign hit_way = lowest(hit_vec);
  assign sel_way = (state == S_SWEEP) ? flush_way : (hit ? hit_way : victim);

  plru_pick u_pick (.tree(entry.plru), .vld(entry.vld), .act_mask(act_mask), .victim(victim));
  secded_check u_ecc (.cw(data_mem[{rd_idx, sel_way}]), .data(dec_data),
                      .single_err(dec_single), .double_err(dec_double));

  always_comb begin
    state_n = state; active_n = active; target_n = target; sweep_n = sweep;
    entry_n = entry; tag_we = 1'b0; data_we = 1'b0; data_wd = '0;
    wb_set = 1'b0; wb_addr_n = '0;
    resp_hit_n = 1'b0; resp_unc_n = 1'b0; err_inc = 1'b0;
    resp_rdata_n = '0; resp_way_n = sel_way;
    if (state == S_SWEEP) begin
      tag_we = 1'b1;
      if (|pend) begin
        wb_set = 1'b1;
        wb_addr_n = {entry.tag[flush_way], sweep};
        entry_n.vld[flush_way] = 1'b0;
        entry_n.dty[flush_way] = 1'b0;
      end else begin
        entry_n.vld = entry.vld & ~range_mask;
        entry_n.dty = entry.dty & ~range_mask;
        if (sweep == IDX_W'(SETS - 1)) begin
          state_n = S_IDLE; active_n = target; sweep_n = '0;
        end else begin
          sweep_n = sweep + 1'b1;
        end
      end
    end else if (cfg_change) begin
      target_n = cfg_ways; state_n = S_SWEEP; sweep_n = '0;
    end else if (accept) begin
      tag_we = 1'b1;
      resp_hit_n = hit;
      entry_n.plru = plru_touch(entry.plru, sel_way);
      if (hit) begin
        if (req_write) begin
          data_we = 1'b1;
          data_wd = secded_enc(req_wdata) ^ req_flip;
          entry_n.dty[sel_way] = 1'b1;
        end else begin
          resp_rdata_n = dec_data;
          resp_unc_n = dec_double;
          err_inc = dec_single;
        end
      end else begin
        if (entry.vld[sel_way] && entry.dty[sel_way]) begin
          wb_set = 1'b1;
          wb_addr_n = {entry.tag[sel_way], req_idx};
        end
        data_we = 1'b1;
        data_wd = secded_enc(req_write ? req_wdata : req_fill) ^ req_flip;
        entry_n.vld[sel_way] = 1'b1;
        entry_n.dty[sel_way] = req_write;
        entry_n.tag[sel_way] = req_tag;
        resp_rdata_n = req_write ? '0 : req_fill;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      state <= S_IDLE; active <= 2'd2; target <= 2'd2; sweep <= '0;
      resp_valid <= 1'b0; resp_hit <= 1'b0; resp_way <= '0; resp_rdata <= '0;
      resp_uncorr <= 1'b0; err_count <= '0;
      wb_valid <= 1'b0; wb_addr <= '0; wb_data <= '0;
      for (int s = 0; s < SETS; s++) tag_mem[s] <= '0;
    end else begin
      state <= state_n; active <= active_n; target <= target_n; sweep <= sweep_n;
      resp_valid <= accept;
      resp_uncorr <= resp_unc_n;
      if (accept) begin
        resp_hit <= resp_hit_n; resp_way <= resp_way_n; resp_rdata <= resp_rdata_n;
      end
      if (err_inc && err_count != 16'hFFFF) err_count <= err_count + 16'd1;
      wb_valid <= wb_set;
      if (wb_set) begin
        wb_addr <= wb_addr_n; wb_data <= dec_data;
      end
      if (tag_we) tag_mem[rd_idx] <= entry_n;
    end
  end

  always_ff @(posedge clk)
    if (data_we) data_mem[{rd_idx, sel_way}] <= data_wd;

  assert_resp_after_accept_R12: assert property (@(posedge clk) disable iff (!rst_i_n)
    (req_valid && req_ready) |=> resp_valid);
  assert_resp_way_powered_R12: assert property (@(posedge clk) disable iff (!rst_i_n)
    resp_valid |-> pwr_en[resp_way]);
  assert_min_two_powered_R7: assert property (@(posedge clk) disable iff (!rst_i_n)
    $countones(pwr_en) >= 2);
  assert_uncorr_on_hit_R10: assert property (@(posedge clk) disable iff (!rst_i_n)
    resp_uncorr |-> (resp_valid && resp_hit));
  assert_err_step_R9: assert property (@(posedge clk) disable iff (!rst_i_n)
    (err_count == $past(err_count)) || (err_count == $past(err_count) + 16'd1));
  assert_ready_low_in_sweep_R6: assert property (@(posedge clk) disable iff (!rst_i_n)
    (wb_valid && !resp_valid) |-> !req_ready);
endmodule

// File: tb/tb_wcache_ctrl.sv
module tb_wcache_ctrl;
  import wcache_pkg::*;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] cfg_ways = 2'd2;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0, req_fill = '0;
  logic [CW-1:0] req_flip = '0;
  logic req_ready, resp_valid, resp_hit, resp_uncorr, wb_valid;
  logic [WAY_W-1:0] resp_way;
  logic [DW-1:0] resp_rdata, wb_data;
  logic [15:0] err_count;
  logic [ADDR_W-1:0] wb_addr;
  logic [WAYS-1:0] pwr_en;
  int compared = 0, mismatched = 0;
  int wb_n;
  logic [ADDR_W-1:0] wb_a_log [8];
  logic [DW-1:0] wb_d_log [8];
  logic [WAYS-1:0] sweep_pwr;

  always #2 clk = ~clk;

  wcache_ctrl dut (.*);

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic access(logic wr, logic [ADDR_W-1:0] a, logic [DW-1:0] wd,
                        logic [DW-1:0] fill, logic [CW-1:0] flip);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = wd;
    req_fill = fill; req_flip = flip;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0; req_flip = '0;
    check("R12 resp one cycle after accept", 64'(resp_valid), 64'd1);
  endtask

  task automatic reconfig(logic [1:0] code);
    int guard;
    wb_n = 0; guard = 0; sweep_pwr = '0;
    cfg_ways = code;
    @(negedge clk);
    sweep_pwr = pwr_en;
    while (!req_ready && guard < 200) begin
      @(negedge clk);
      guard++;
      if (wb_valid && wb_n < 8) begin
        wb_a_log[wb_n] = wb_addr; wb_d_log[wb_n] = wb_data; wb_n++;
      end
    end
  endtask

  task automatic t_reset();
    check("R11 ready", 64'(req_ready), 64'd1);
    check("R11 pwr_en", 64'(pwr_en), 64'hFF);
    check("R11 err_count", 64'(err_count), 64'd0);
    check("R11 resp_valid", 64'(resp_valid), 64'd0);
  endtask

  task automatic t_basic();
    access(1, 12'h015, 32'hD1D1_0001, 0, 0);
    check("R2 write miss", 64'(resp_hit), 0); check("R2 way", 64'(resp_way), 0);
    access(0, 12'h015, 0, 0, 0);
    check("R1 read hit", 64'(resp_hit), 1); check("R1 data", 64'(resp_rdata), 64'hD1D1_0001);
    access(0, 12'h025, 0, 32'hF00D_0002, 0);
    check("R2 read miss hit", 64'(resp_hit), 0); check("R2 fill data", 64'(resp_rdata), 64'hF00D_0002);
    check("R3 lowest invalid", 64'(resp_way), 1); check("R4 clean no wb", 64'(wb_valid), 0);
    access(0, 12'h025, 0, 0, 0);
    check("R2 fill kept", 64'(resp_rdata), 64'hF00D_0002);
  endtask

  task automatic t_evict();
    for (int t = 3; t <= 8; t++) begin
      access(0, ADDR_W'((t << 4) | 5), 0, DW'(t), 0);
      check("R3 fill way", 64'(resp_way), 64'(t - 1));
    end
    access(1, 12'h095, 32'hD3D3_0003, 0, 0);
    check("R3 plru victim", 64'(resp_way), 0);
    check("R4 wb pulse", 64'(wb_valid), 1);
    check("R4 wb addr", 64'(wb_addr), 64'h015);
    check("R4 wb data", 64'(wb_data), 64'hD1D1_0001);
  endtask

  task automatic t_shrink4();
    access(1, 12'h065, 32'hD5D5_0005, 0, 0);
    check("R1 write hit way", 64'(resp_way), 5);
    access(1, 12'h055, 32'hD4D4_0004, 0, 0);
    reconfig(2'd1);
    check("R7 powered during sweep", 64'(sweep_pwr), 64'hFF);
    check("R6 wb count", 64'(wb_n), 2);
    check("R6 first wb", 64'(wb_a_log[0]), 64'h055);
    check("R6 first data", 64'(wb_d_log[0]), 64'hD4D4_0004);
    check("R6 second wb", 64'(wb_a_log[1]), 64'h065);
    check("R6 second data", 64'(wb_d_log[1]), 64'hD5D5_0005);
    check("R7 pwr 4 ways", 64'(pwr_en), 64'h0F);
    access(0, 12'h055, 0, 32'h5555_0000, 0);
    check("R6 gated line misses", 64'(resp_hit), 0);
    check("R3 plru in 4 ways", 64'(resp_way), 2);
    access(0, 12'h045, 0, 0, 0);
    check("R1 kept way hit", 64'(resp_hit), 1); check("R1 kept way", 64'(resp_way), 3);
  endtask

  task automatic t_illegal();
    cfg_ways = 2'd3;
    @(negedge clk); @(negedge clk);
    check("R5 code3 ready", 64'(req_ready), 1);
    check("R5 code3 pwr", 64'(pwr_en), 64'h0F);
    cfg_ways = 2'd1;
  endtask

  task automatic t_two_way();
    reconfig(2'd0);
    check("R6 clean ways no wb", 64'(wb_n), 0);
    check("R7 pwr 2 ways", 64'(pwr_en), 64'h03);
    access(0, 12'h025, 0, 0, 0);
    check("R3 hit way1", 64'(resp_way), 1);
    access(0, 12'h0A5, 0, 32'hAAAA_0000, 0);
    check("R3 2-way victim", 64'(resp_way), 0);
    check("R4 dirty wb", 64'(wb_valid), 1);
    check("R4 wb addr", 64'(wb_addr), 64'h095);
    check("R4 wb data", 64'(wb_data), 64'hD3D3_0003);
    access(0, 12'h0B5, 0, 32'hBBBB_0000, 0);
    check("R3 alternate victim", 64'(resp_way), 1);
    check("R4 clean victim no wb", 64'(wb_valid), 0);
  endtask

  task automatic t_grow();
    reconfig(2'd2);
    check("R7 pwr 8 ways", 64'(pwr_en), 64'hFF);
    check("R8 grow no wb", 64'(wb_n), 0);
    access(0, 12'h055, 0, 32'h1, 0);
    check("R8 no false hit", 64'(resp_hit), 0);
    check("R8 lowest returning way", 64'(resp_way), 2);
  endtask

  task automatic t_ecc();
    access(1, 12'h100, 32'h1234_5678, 0, 39'h20);
    access(0, 12'h100, 0, 0, 0);
    check("R9 corrected data", 64'(resp_rdata), 64'h1234_5678);
    check("R9 err_count", 64'(err_count), 1);
    check("R9 no uncorr", 64'(resp_uncorr), 0);
    access(1, 12'h101, 32'hCAFE_F00D, 0, 39'h208);
    access(0, 12'h101, 0, 0, 0);
    check("R10 uncorr flag", 64'(resp_uncorr), 1);
    check("R10 count unchanged", 64'(err_count), 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_basic();
    t_evict();
    t_shrink4();
    t_illegal();
    t_two_way();
    t_grow();
    t_ecc();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    compared++; mismatched++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule